// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA engine for a disk interface. Software sees an 8-byte register window with three registers: a command byte, a status byte and a 32-bit pointer to a table of transfer descriptors. A second channel is a second instance whose window sits 8 bytes higher in the host map. Once started, the engine reads descriptors from memory and moves data to or from the drive. At the end it reports completion or failure in the status byte and on an interrupt line.

Each descriptor is 8 bytes and is fetched as one 64-bit read:
- The low dword is the buffer address.
- Bits 15:0 of the high dword are the byte count. A count of 0 means 64 KB.
- Bit 31 of the high dword marks the last entry.

The drive side uses a word handshake. While the drive holds `devReq`, the engine moves one 16-bit word per cycle and counts the remaining bytes down. If the drive raises `devDone` before the table is used up, the run ends with an error. Bus timing toward the drive is not part of this block.

Register map:

| Byte offset | Bits | Meaning |
|---|---|---|
| 0 (command) | 0 | start/stop |
| 0 (command) | 3 | direction; 1 means the device is read into memory |
| 2 (status) | 0 | active |
| 2 (status) | 1 | error |
| 2 (status) | 2 | interrupt |
| 2 (status) | 5, 6 | DMA-capable flags for drive 0 and drive 1 |
| 2 (status) | 7 | read-only simplex flag |
| 4 | 31:0 | descriptor table pointer |

Top module: `busdma_channel`

## Requirements
- R1: After reset the command byte, status byte (bit 7 aside) and table pointer read 0, `irq` is 0 and `memReq` is 0.
- R2: The command byte (dword 0, lane 0) keeps only bit 0 (start) and bit 3 (direction); its other bits read 0. The table pointer (dword 1) keeps bits 31:2, and bits 1:0 read 0.
- R3: Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit; writing 0 leaves it. A hardware set in the same cycle as a clear wins.
- R4: Status bits 5 and 6 are freely writable. Bit 7 always reads the `SIMPLEX` parameter. Bit 0 (active) ignores host writes.
- R5: A 0-to-1 write of the start bit sets active. The engine then fetches the first descriptor at the table pointer, and later descriptors at +8 bytes each. Low dword = buffer address, high dword bits 15:0 = byte count, high dword bit 31 = last entry.
- R6: Each `dmaBeat` moves 2 bytes. `xferAddr` starts at the buffer address and rises by 2 per beat. A byte count of 0 means 65536 bytes, and count bit 0 is ignored.
- R7: The final beat of the descriptor marked last leaves status bits 2:0 at 100b (interrupt, not active, no error).
- R8: `devDone` while a transfer is outstanding ends it with status bits 2:0 at 110b.
- R9: Writing start = 0 mid-transfer clears active on the next edge, stops further beats, and leaves interrupt and error unchanged.
- R10: `irq` follows status bit 2, and `xferToMem` follows command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostWordSel | input | 1 | Dword in the window: 0 = command/status, 1 = table pointer |
| hostBe | input | 4 | Byte lane enables |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Read data of the selected dword (combinational) |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | 32 | Descriptor address |
| memAck | input | 1 | Descriptor data valid |
| memRdData | input | 64 | Descriptor contents |
| devReq | input | 1 | Drive is ready for a word |
| devDone | input | 1 | Drive has stopped the transfer |
| dmaBeat | output | 1 | One word moves at this clock edge |
| xferAddr | output | 32 | Memory address of the current word |
| xferToMem | output | 1 | Direction: 1 = device to memory |
| irq | output | 1 | Interrupt request |

## Verification
Register effects of a host write, and status changes from a finished, failed or halted run, appear on the edge after the causing cycle. The bench therefore drives on falling edges and samples the next falling edge.

The path from a start write to the first beat takes two edges: one to set active and request the descriptor, and one to take the descriptor in. `dmaBeat` is combinational from `devReq` in the move state, so the bench counts beats at the same falling edge at which it holds `devReq`. Checks of "no further beats" after a halt sample that same signal over several cycles while `devReq` stays high.

// File: rtl/busdma_pkg.sv
package busdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic launch;     // begin a run at the table pointer
    logic descLoad;   // capture fetched descriptor
    logic beat;       // one word moved
    logic finishOk;   // normal end of table
    logic finishErr;  // drive ended early
    logic halt;       // software stop
  } dmaStrobe_t;

endpackage

// File: rtl/busdma_regs.sv
module busdma_regs
  import busdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int SIMPLEX = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWe,
  input  logic            hostWordSel,
  input  logic [3:0]      hostBe,
  input  logic [31:0]     hostWdata,
  output logic [31:0]     hostRdata,
  input  logic [2*AW-1:0] memRdData,
  input  dmaStrobe_t      stb,
  output logic            startEv,
  output logic            stopEv,
  output logic            active,
  output logic            lastBeat,
  output logic            lastDesc,
  output logic [AW-1:0]   memAddr,
  output logic [AW-1:0]   xferAddr,
  output logic            xferToMem,
  output logic            irq
);

  localparam logic SIMPLEX_BIT = (SIMPLEX != 0);
  localparam int   WORD_W      = CW;
  localparam logic [WORD_W-1:0] FULL_WORDS = {1'b1, {(WORD_W-1){1'b0}}};

  logic              cmdStart, cmdDir;
  logic              stActive, stErr, stIntr;
  logic [1:0]        stCap;
  logic [AW-1:2]     tblPtr;
  logic [AW-1:2]     descPtr;
  logic [AW-1:1]     curAddr;
  logic [WORD_W-1:0] remainW;
  logic              wrCmd, wrStat;
  logic [CW-2:0]     cntWords;
  logic [7:0]        statusByte;
  logic              unusedBits;

  assign wrCmd    = hostWe && !hostWordSel && hostBe[0];
  assign wrStat   = hostWe && !hostWordSel && hostBe[2];
  assign startEv  = wrCmd && hostWdata[0] && !cmdStart;
  assign stopEv   = wrCmd && !hostWdata[0] && cmdStart;
  assign cntWords = memRdData[AW+CW-1:AW+1];
  assign unusedBits = ^{memRdData[0], memRdData[AW], memRdData[2*AW-2:AW+CW], hostWdata[1]};

  // Command byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStart <= 1'b0;
      cmdDir   <= 1'b0;
    end else if (wrCmd) begin
      cmdStart <= hostWdata[0];
      cmdDir   <= hostWdata[3];
    end
  end

  // Table pointer, one byte lane at a time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblPtr <= '0;
    end else if (hostWe && hostWordSel) begin
      if (hostBe[0]) tblPtr[7:2] <= hostWdata[7:2];
      for (int b = 1; b < 4; b++)
        if (hostBe[b]) tblPtr[8*b +: 8] <= hostWdata[8*b +: 8];
    end
  end

  // Status byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stActive <= 1'b0;
      stErr    <= 1'b0;
      stIntr   <= 1'b0;
      stCap    <= 2'b00;
    end else begin
      if (stb.halt || stb.finishOk || stb.finishErr) stActive <= 1'b0;
      else if (stb.launch)                           stActive <= 1'b1;

      if (stb.finishOk || stb.finishErr)       stIntr <= 1'b1;
      else if (wrStat && hostWdata[18])        stIntr <= 1'b0;

      if (stb.finishErr)                       stErr <= 1'b0 | 1'b1;
      else if (wrStat && hostWdata[17])        stErr <= 1'b0;

      if (wrStat) stCap <= hostWdata[22:21];
    end
  end

  // Descriptor walk and word counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr  <= '0;
      curAddr  <= '0;
      remainW  <= '0;
      lastDesc <= 1'b0;
    end else begin
      if (stb.launch)        descPtr <= tblPtr;
      else if (stb.descLoad) descPtr <= descPtr + 2'd2;

      if (stb.descLoad) begin
        curAddr  <= memRdData[AW-1:1];
        remainW  <= (cntWords == '0) ? FULL_WORDS : {1'b0, cntWords};
        lastDesc <= memRdData[2*AW-1];
      end else if (stb.beat) begin
        curAddr <= curAddr + 1'b1;
        remainW <= remainW - 1'b1;
      end
    end
  end

  assign lastBeat   = (remainW == {{(WORD_W-1){1'b0}}, 1'b1});
  assign active     = stActive;
  assign memAddr    = {descPtr, 2'b00};
  assign xferAddr   = {curAddr, 1'b0};
  assign xferToMem  = cmdDir;
  assign irq        = stIntr;
  assign statusByte = {SIMPLEX_BIT, stCap, 2'b00, stIntr, stErr, stActive};
  assign hostRdata  = hostWordSel ? {tblPtr, 2'b00}
                                  : {8'h00, statusByte, 8'h00, 4'h0, cmdDir, 2'b00, cmdStart};

  // R5
  launch_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> stActive && (memAddr == {$past(tblPtr), 2'b00}));

  // R7
  done_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finishOk |=> stIntr && !stActive);

  // R8
  err_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finishErr |=> stIntr && stErr && !stActive);

  // R3
  w1c_intr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && hostWdata[18] && !stb.finishOk && !stb.finishErr) |=> !stIntr);

endmodule

// File: rtl/busdma_ctrl.sv
module busdma_ctrl
  import busdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       memAck,
  input  logic       devReq,
  input  logic       devDone,
  input  logic       lastBeat,
  input  logic       lastDesc,
  input  logic       active,
  output dmaStrobe_t stb,
  output logic       memReq,
  output logic       dmaBeat
);

  dmaState_t state, nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startEv) begin
          stb.launch = 1'b1;
          nxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (stopEv) begin
          stb.halt = 1'b1;
          nxt = ST_IDLE;
        end else if (devDone) begin
          stb.finishErr = 1'b1;
          nxt = ST_IDLE;
        end else if (memAck) begin
          stb.descLoad = 1'b1;
          nxt = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (stopEv) begin
          stb.halt = 1'b1;
          nxt = ST_IDLE;
        end else if (devReq) begin
          stb.beat = 1'b1;
          if (lastBeat && lastDesc) begin
            stb.finishOk = 1'b1;
            nxt = ST_IDLE;
          end else if (lastBeat) begin
            nxt = ST_FETCH;
          end
        end else if (devDone) begin
          stb.finishErr = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign memReq  = (state == ST_FETCH);
  assign dmaBeat = stb.beat;

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && state != ST_IDLE) |=> (state == ST_IDLE) && !active);

  // R6
  beat_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaBeat |-> active);

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.launch, stb.descLoad, stb.finishOk, stb.finishErr, stb.halt}));

endmodule

// File: rtl/busdma_channel.sv
module busdma_channel
  import busdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int SIMPLEX = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWe,
  input  logic            hostWordSel,
  input  logic [3:0]      hostBe,
  input  logic [31:0]     hostWdata,
  output logic [31:0]     hostRdata,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  input  logic            memAck,
  input  logic [2*AW-1:0] memRdData,
  input  logic            devReq,
  input  logic            devDone,
  output logic            dmaBeat,
  output logic [AW-1:0]   xferAddr,
  output logic            xferToMem,
  output logic            irq
);

  dmaStrobe_t stb;
  logic startEv, stopEv, active, lastBeat, lastDesc;

  busdma_regs #(.AW(AW), .CW(CW), .SIMPLEX(SIMPLEX)) uRegs (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostWordSel(hostWordSel),
    .hostBe(hostBe), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memRdData(memRdData), .stb(stb), .startEv(startEv), .stopEv(stopEv),
    .active(active), .lastBeat(lastBeat), .lastDesc(lastDesc),
    .memAddr(memAddr), .xferAddr(xferAddr), .xferToMem(xferToMem), .irq(irq)
  );

  busdma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .memAck(memAck), .devReq(devReq), .devDone(devDone),
    .lastBeat(lastBeat), .lastDesc(lastDesc), .active(active),
    .stb(stb), .memReq(memReq), .dmaBeat(dmaBeat)
  );

endmodule

// File: tb/busdma_channel_test.sv
`timescale 1ns/1ps
module busdma_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0, hostWordSel = 1'b0;
  logic [3:0]  hostBe = 4'h0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        memReq, memAck;
  logic [31:0] memAddr, xferAddr;
  logic [63:0] memRdData;
  logic        devReq = 1'b0, devDone = 1'b0;
  logic        dmaBeat, xferToMem, irq;

  int checks = 0, failures = 0;
  int beats;
  logic [31:0] firstA, lastA;

  always #2 clk = ~clk;

  busdma_channel uut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostWordSel(hostWordSel),
    .hostBe(hostBe), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdData(memRdData),
    .devReq(devReq), .devDone(devDone), .dmaBeat(dmaBeat),
    .xferAddr(xferAddr), .xferToMem(xferToMem), .irq(irq)
  );

  // Descriptor memory: {control dword, address dword}
  function automatic logic [63:0] descAt(input logic [31:0] a);
    case (a)
      32'h1000: descAt = {32'h0000_0006, 32'h0000_2000};
      32'h1008: descAt = {32'h8000_0004, 32'h0000_3000};
      32'h4000: descAt = {32'h8000_0000, 32'h0000_5000};
      32'h6000: descAt = {32'h8000_0008, 32'h0000_7000};
      32'h6100: descAt = {32'h0000_0010, 32'h0000_7100};
      default:  descAt = 64'h0;
    endcase
  endfunction

  assign memAck    = memReq;
  assign memRdData = descAt(memAddr);

  typedef struct packed {
    logic        sel;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
  } regVec_t;

  localparam regVec_t VECS [5] = '{
    '{1'b1, 4'hF, 32'h1234_5677, 32'h1234_5674},  // R2 pointer low bits
    '{1'b0, 4'h4, 32'h00E1_0000, 32'h0060_0000},  // R4 cap rw, simplex/active ro
    '{1'b0, 4'h4, 32'h0000_0000, 32'h0000_0000},  // R4 cap cleared
    '{1'b0, 4'h1, 32'h0000_00FE, 32'h0000_0008},  // R2 only dir kept
    '{1'b0, 4'h1, 32'h0000_0000, 32'h0000_0000}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostWordSel = sel; hostBe = be; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0; hostWordSel = 1'b0; hostBe = 4'h0;
    #1;
  endtask

  task automatic readWord(input logic sel, output logic [31:0] d);
    hostWordSel = sel;
    #1 d = hostRdata;
    hostWordSel = 1'b0;
    #0;
  endtask

  task automatic runXfer(input int maxCyc);
    beats = 0; firstA = '0; lastA = '0;
    for (int c = 0; c < maxCyc; c++) begin
      #0.5;
      if (!hostRdata[16]) break;
      if (dmaBeat) begin
        if (beats == 0) firstA = xferAddr;
        lastA = xferAddr;
        beats++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    readWord(1'b0, rd); chk("R1 word0", rd, 32'h0);
    readWord(1'b1, rd); chk("R1 pointer", rd, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 memReq", {31'h0, memReq}, 32'h0);

    // Register vectors
    for (int i = 0; i < 5; i++) begin
      hostWrite(VECS[i].sel, VECS[i].be, VECS[i].wdata);
      readWord(VECS[i].sel, rd);
      chk($sformatf("R2/R4 vec%0d", i), rd, VECS[i].exp);
    end

    // Two-descriptor run into memory
    hostWrite(1'b1, 4'hF, 32'h0000_1000);
    devReq = 1'b1;
    hostWrite(1'b0, 4'h1, 32'h0000_0009);
    chk("R10 xferToMem", {31'h0, xferToMem}, 32'h1);
    runXfer(100);
    chk("R5 beats over two descriptors", beats, 5);
    chk("R6 first address", firstA, 32'h2000);
    chk("R5 second descriptor address", lastA, 32'h3002);
    readWord(1'b0, rd);
    chk("R7 status after end", {24'h0, rd[23:16]}, 32'h04);
    chk("R10 irq", {31'h0, irq}, 32'h1);

    // R3 write 0 leaves interrupt, write 1 clears it
    hostWrite(1'b0, 4'h4, 32'h0002_0000);
    readWord(1'b0, rd);
    chk("R3 write zero to intr", {24'h0, rd[23:16]}, 32'h04);
    hostWrite(1'b0, 4'h4, 32'h0004_0000);
    readWord(1'b0, rd);
    chk("R3 clear intr", {24'h0, rd[23:16]}, 32'h00);

    // 64 KB descriptor
    hostWrite(1'b0, 4'h1, 32'h0);
    hostWrite(1'b1, 4'hF, 32'h0000_4000);
    hostWrite(1'b0, 4'h1, 32'h0000_0001);
    chk("R10 xferToMem low", {31'h0, xferToMem}, 32'h0);
    runXfer(40000);
    chk("R6 zero count beats", beats, 32768);
    chk("R6 zero count last address", lastA, 32'h0001_4FFE);
    readWord(1'b0, rd);
    chk("R7 status after 64K", {24'h0, rd[23:16]}, 32'h04);
    hostWrite(1'b0, 4'h4, 32'h0004_0000);
    hostWrite(1'b0, 4'h1, 32'h0);

    // Drive ends early
    devReq = 1'b0;
    hostWrite(1'b1, 4'hF, 32'h0000_6100);
    hostWrite(1'b0, 4'h1, 32'h0000_0001);
    @(negedge clk);
    beats = 0;
    for (int k = 0; k < 2; k++) begin
      devReq = 1'b1; #1;
      if (dmaBeat) beats++;
      @(negedge clk);
    end
    devReq = 1'b0; devDone = 1'b1;
    @(negedge clk);
    devDone = 1'b0;
    readWord(1'b0, rd);
    chk("R8 beats before end", beats, 2);
    chk("R8 status error", {24'h0, rd[23:16]}, 32'h06);
    hostWrite(1'b0, 4'h4, 32'h0000_0000);
    readWord(1'b0, rd);
    chk("R3 write zero keeps both", {24'h0, rd[23:16]}, 32'h06);
    hostWrite(1'b0, 4'h4, 32'h0002_0000);
    readWord(1'b0, rd);
    chk("R3 clear error only", {24'h0, rd[23:16]}, 32'h04);
    hostWrite(1'b0, 4'h4, 32'h0004_0000);
    hostWrite(1'b0, 4'h1, 32'h0);

    // Software halt mid-transfer
    hostWrite(1'b1, 4'hF, 32'h0000_6000);
    hostWrite(1'b0, 4'h1, 32'h0000_0001);
    @(negedge clk);
    beats = 0;
    devReq = 1'b1; #1;
    if (dmaBeat) beats++;
    @(negedge clk);
    devReq = 1'b0;
    hostWrite(1'b0, 4'h1, 32'h0000_0000);
    readWord(1'b0, rd);
    chk("R9 status after halt", {24'h0, rd[23:16]}, 32'h00);
    devReq = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #0.5;
      if (dmaBeat) beats++;
      @(negedge clk);
    end
    devReq = 1'b0;
    chk("R9 no beats after halt", beats, 1);
    chk("R9 irq stays low", {31'h0, irq}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule